// File: doc/BRIEF.md
# Cycle-Tick Down-Counting Interrupt Timer

This block raises an interrupt after software-chosen number of processor cycles. Software fills a 16-bit reload value one byte at a time. It then writes a single control register. That one write clears any pending interrupt, copies the reload value into the down-counter, and arms or disarms the timer from data bit 0.

While the timer is armed, every asserted cycle tick lowers the count by one. The interrupt flag rises on the tick that brings the count to zero. After that the counter rests at zero and the flag stays high until the next control write. If the timer is armed while the reload value is zero, the flag rises straight away, without any tick.

The register port is a plain write strobe with a 4-bit index and an 8-bit data byte. Writes take effect on the clock edge where the strobe is high, and there is no back-pressure. The interrupt output is a level. Reset is asynchronous and active low.

Top module: `cyc_irq_timer`

## Requirements
- R1: While reset is asserted and after it is released, `irq_pend` is 0, and the reload value, counter and arm state are all zero. A control write that arms the timer straight after reset therefore raises `irq_pend` at once.
- R2: A write to index 11 replaces bits 7:0 of the reload value. A write to index 12 replaces bits 15:8. Each write leaves the other byte unchanged.
- R3: A write to index 10 (the control register) clears `irq_pend`, loads the counter from the reload value, and sets the arm state to data bit 0. The other data bits have no effect. The result is visible from the cycle after the write.
- R4: A control write with bit 0 set, made while the reload value is zero, makes `irq_pend` 1 from the cycle after the write.
- R5: While the timer is armed, each cycle with `cyc_tick` high lowers the counter by one. With a reload value N > 0, `irq_pend` first reads 1 in the cycle after the N-th tick, and reads 0 after N-1 ticks.
- R6: While the timer is disarmed, ticks are ignored, the counter holds its value and `irq_pend` does not rise.
- R7: After firing, the counter stays at zero and does not wrap. `irq_pend` stays 1 through any number of further ticks until a control write.
- R8: When a control write and a tick arrive in the same cycle, the control write wins and that tick is not counted. Counting starts with the next tick.
- R9: Writes to indices 0–9 and 13–15 have no effect. They do not acknowledge the interrupt, change the reload value or change the arm state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_tick | input | 1 | One-cycle pulse, once per processor cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register index of the write |
| reg_wdata | input | 8 | Write data byte |
| irq_pend | output | 1 | Interrupt pending, active high |

## Verification
The case most likely to break is a control write and a cycle tick arriving in the same cycle. A reload that also counted the tick would fire one tick early.

The bench loads a reload value of 2. It drives the arming write and a tick on the same edge, then checks that `irq_pend` is still low after one more tick and goes high only after the second. A second case lands a control write on top of a tick while the flag is already pending. There the bench checks that the acknowledge wins and the reload restarts the count.

// File: rtl/cyc_irq_timer_pkg.sv
package cyc_irq_timer_pkg;
  parameter int TMR_DATA_W = 8;
  parameter int TMR_IDX_W  = 4;
  parameter int TMR_CNT_W  = 16;
  parameter int TMR_LANES  = TMR_CNT_W / TMR_DATA_W;

  // Register indices; the reload bytes occupy consecutive indices, low byte first
  parameter int TMR_IDX_CTRL  = 10;
  parameter int TMR_IDX_LOAD0 = 11;
  parameter int TMR_ARM_BIT   = 0;

  typedef struct packed {
    logic strobe;
    logic arm;
  } ctl_cmd_t;
endpackage

// File: rtl/cyc_irq_timer_regs.sv
module cyc_irq_timer_regs
  import cyc_irq_timer_pkg::*;
#(
  parameter int DATA_W = TMR_DATA_W,
  parameter int IDX_W  = TMR_IDX_W,
  parameter int CNT_W  = TMR_CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [CNT_W-1:0]  reload_o,
  output ctl_cmd_t          ctl_o
);
  localparam int LANES = CNT_W / DATA_W;

  always_comb begin
    ctl_o.strobe = reg_wr && (reg_idx == IDX_W'(TMR_IDX_CTRL));
    ctl_o.arm    = reg_wdata[TMR_ARM_BIT];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DATA_W-1:0] byte_q;
    logic              hit;
    assign hit = reg_wr && (reg_idx == IDX_W'(TMR_IDX_LOAD0 + g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
      end else if (hit) begin
        byte_q <= reg_wdata;
      end
    end
    assign reload_o[g*DATA_W +: DATA_W] = byte_q;
  end
endmodule

// File: rtl/cyc_irq_timer_core.sv
module cyc_irq_timer_core
  import cyc_irq_timer_pkg::*;
#(
  parameter int CNT_W = TMR_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_tick,
  input  ctl_cmd_t         ctl_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             arm_o,
  output logic             pend_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             arm_q;
  logic             pend_q;
  logic             step;
  logic             last_step;
  logic             reload_zero;

  assign reload_zero = (reload_i == '0);
  assign step        = arm_q && cyc_tick && (cnt_q != '0);
  assign last_step   = step && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      arm_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (ctl_i.strobe) begin
      cnt_q  <= reload_i;
      arm_q  <= ctl_i.arm;
      pend_q <= ctl_i.arm && reload_zero;
    end else if (step) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (last_step) pend_q <= 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign arm_o  = arm_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
  import cyc_irq_timer_pkg::*;
#(
  parameter int DATA_W = TMR_DATA_W,
  parameter int IDX_W  = TMR_IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_tick,
  input  logic              reg_wr,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              irq_pend
);
  localparam int CNT_W = 2 * DATA_W;

  ctl_cmd_t         ctl;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] cnt;
  logic             arm;

  cyc_irq_timer_regs #(.DATA_W(DATA_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_idx  (reg_idx),
    .reg_wdata(reg_wdata),
    .reload_o (reload),
    .ctl_o    (ctl)
  );

  cyc_irq_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .cyc_tick(cyc_tick),
    .ctl_i   (ctl),
    .reload_i(reload),
    .cnt_o   (cnt),
    .arm_o   (arm),
    .pend_o  (irq_pend)
  );
endmodule

// File: rtl/cyc_irq_timer_chk.sv
module cyc_irq_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_tick,
  input logic             ctl_wr,
  input logic             ctl_arm,
  input logic [CNT_W-1:0] reload,
  input logic [CNT_W-1:0] cnt,
  input logic             arm,
  input logic             irq_pend
);
  AST_RELOAD_ON_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (cnt == $past(reload)) && (arm == $past(ctl_arm))); // R3
  AST_ACK_ON_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_arm) |=> !irq_pend); // R3
  AST_ZERO_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_arm && reload == '0) |=> irq_pend); // R4
  AST_TICK_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_wr && arm && cyc_tick && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R5
  AST_LAST_TICK_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_wr && arm && cyc_tick && cnt == CNT_W'(1)) |=> irq_pend); // R5
  AST_DISARMED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_wr && !arm) |=> $stable(cnt)); // R6
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_wr && cnt == '0) |=> (cnt == '0)); // R7
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_wr && irq_pend) |=> irq_pend); // R7
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_wr && !irq_pend && !(arm && cyc_tick && cnt == CNT_W'(1))) |=> !irq_pend); // R6
  always_comb begin
    if (!rst_n) AST_RESET_QUIET: assert (!irq_pend); // R1
  end
endmodule

bind cyc_irq_timer cyc_irq_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cyc_tick(cyc_tick),
  .ctl_wr  (ctl.strobe),
  .ctl_arm (ctl.arm),
  .reload  (reload),
  .cnt     (cnt),
  .arm     (arm),
  .irq_pend(irq_pend)
);

// File: tb/sim_cyc_irq_timer.sv
module sim_cyc_irq_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_tick = 1'b0;
  logic       reg_wr = 1'b0;
  logic [3:0] reg_idx = '0;
  logic [7:0] reg_wdata = '0;
  logic       irq_pend;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cyc_irq_timer u0 (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .reg_wr(reg_wr),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .irq_pend(irq_pend)
  );

  // {reload[15:0], ticks[15:0], arm, expected irq}
  localparam int NV = 12;
  localparam logic [33:0] VEC [NV] = '{
    {16'd0,      16'd0,   1'b1, 1'b1},
    {16'd0,      16'd5,   1'b0, 1'b0},
    {16'd3,      16'd2,   1'b1, 1'b0},
    {16'd3,      16'd3,   1'b1, 1'b1},
    {16'd1,      16'd0,   1'b1, 1'b0},
    {16'd1,      16'd1,   1'b1, 1'b1},
    {16'h0100,   16'd255, 1'b1, 1'b0},
    {16'h0100,   16'd256, 1'b1, 1'b1},
    {16'd5,      16'd10,  1'b0, 1'b0},
    {16'h0102,   16'd258, 1'b1, 1'b1},
    {16'd4,      16'd20,  1'b1, 1'b1},
    {16'h00FF,   16'd254, 1'b1, 1'b0}
  };

  task automatic check(input logic exp, input string req);
    n_chk++;
    if (irq_pend !== exp) begin
      n_bad++;
      $display("FAIL %s: irq_pend=%0b expected=%0b", req, irq_pend, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = 4'(idx); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      cyc_tick = 1'b1;
      repeat (n) @(negedge clk);
      cyc_tick = 1'b0;
    end
  endtask

  task automatic load(input logic [15:0] v);
    wr(11, v[7:0]);
    wr(12, v[15:8]);
  endtask

  initial begin
    #100000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1'b0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b0, "R1 after reset");

    // table walk (R2 R3 R4 R5 R6 R7)
    for (int i = 0; i < NV; i++) begin
      logic [15:0] lv;
      logic [15:0] tn;
      lv = VEC[i][33:18];
      tn = VEC[i][17:2];
      load(lv);
      wr(10, {7'h55, VEC[i][1]});
      ticks(int'(tn));
      check(VEC[i][0], $sformatf("R5 vector %0d", i));
    end

    // R1: reset clears reload, so arming right after reset fires at once
    load(16'h1234);
    wr(10, 8'h01);
    rst_n = 1'b0;
    @(negedge clk);
    check(1'b0, "R1 reset mid-run");
    rst_n = 1'b1;
    wr(10, 8'h01);
    check(1'b1, "R1 reload cleared by reset");

    // R8: control write and tick in the same cycle
    load(16'd2);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = 4'd10; reg_wdata = 8'h01; cyc_tick = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; cyc_tick = 1'b0;
    check(1'b0, "R8 ack wins over same-cycle tick");
    ticks(1);
    check(1'b0, "R8 colliding tick not counted");
    ticks(1);
    check(1'b1, "R8 fires after two further ticks");

    // R7: sticky through ticks; R9: other indices do not ack
    ticks(40);
    check(1'b1, "R7 pending sticky, no wrap");
    wr(9, 8'hFF);
    wr(13, 8'h00);
    wr(0, 8'h00);
    check(1'b1, "R9 unused index does not acknowledge");

    // R8: control write on top of a tick while pending restarts count
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = 4'd10; reg_wdata = 8'h01; cyc_tick = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; cyc_tick = 1'b0;
    check(1'b0, "R8 ack while pending and ticking");
    ticks(2);
    check(1'b1, "R8 reload restarts count");

    // R3: disarm write acknowledges; other data bits ignored
    wr(10, 8'hFE);
    check(1'b0, "R3 disarm acknowledges");
    ticks(10);
    check(1'b0, "R6 disarmed ignores ticks");

    // R9: unused index writes leave reload intact
    load(16'd3);
    wr(14, 8'h00);
    wr(15, 8'h00);
    wr(10, 8'h01);
    ticks(2);
    check(1'b0, "R9 reload unchanged, not yet");
    ticks(1);
    check(1'b1, "R9 reload unchanged, fires at 3");

    // R2: high byte write keeps low byte
    load(16'd0);
    wr(11, 8'd2);
    wr(12, 8'd0);
    wr(10, 8'h01);
    check(1'b0, "R2 low byte kept after high write");
    ticks(2);
    check(1'b1, "R2 fires at low byte value");

    // R4 with nonzero pattern in other data bits
    load(16'd0);
    wr(10, 8'h81);
    check(1'b1, "R4 immediate fire on zero reload");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule